// File: doc/BRIEF.md
# Single-Clock FIFO with Early-Warning and Threshold Flags

The block is a first-in first-out queue. Writer and reader share one clock. The storage is an inferred register array of `DEPTH` words, and every one of those words can hold data. The write and read pointers each carry one extra wrap bit. Equal pointers mean the queue is empty. Equal addresses with different wrap bits mean it is full. The occupancy is the difference of the two pointers, and it is presented on a port.

Around the exact full and empty flags the block gives three kinds of warning:

- A pair of early flags that rise one entry before the exact ones.
- A pair of almost flags, each with a programmable margin. The two margins load together through a strobe, and reset sets both to one eighth of the depth.
- Overflow and underflow pulses, one cycle long. A producer sees an overflow pulse when it writes into a full queue without a read in the same cycle. A consumer sees an underflow pulse when it reads an empty queue. In both cases the refused access leaves the queue untouched.

Read data is registered and appears in the cycle after an accepted read strobe.

Top module: `flagged_fifo`

## Requirements
- R1: While reset is active, and after it is released, `count` is 0, `empty` and `empty_early` are 1, and `full`, `overflow` and `underflow` are 0. `rd_data` is 0. Both thresholds are set to DEPTH/8.
- R2: Words leave in the order they were written. The word for an accepted read appears on `rd_data` one clock after the edge that samples `rd_en`. `rd_data` holds its value in every cycle with no accepted read.
- R3: Starting from empty, DEPTH writes with no reads are all accepted, and the queue then reports `full`=1 with `count`=DEPTH.
- R4: Each accepted write adds 1 to `count` and each accepted read subtracts 1. When both are accepted in the same cycle, `count` is unchanged.
- R5: A write while full with no read is ignored: `count` and the stored words are unchanged. `overflow` is 1 for exactly the one cycle after that edge.
- R6: A read while empty is ignored. `underflow` is 1 for exactly the one cycle after that edge, and `rd_data` keeps its previous value.
- R7: A read and a write in the same cycle on a full queue are both accepted. `count` stays DEPTH and no overflow is flagged. On an empty queue the write is accepted and the read is refused: `count` becomes 1 and `underflow` pulses.
- R8: `full_early` is 1 whenever `count` >= DEPTH-1. `empty_early` is 1 whenever `count` <= 1.
- R9: `almost_full` is 1 whenever `count` >= DEPTH minus the almost-full threshold. `almost_empty` is 1 whenever `count` <= the almost-empty threshold.
- R10: When `thr_load` is 1 at a clock edge, `af_level` and `ae_level` become the two thresholds, and the flags use them from the next cycle. Reset restores both thresholds to DEPTH/8.
- R11: `full` is 1 exactly when `count` equals DEPTH. `empty` is 1 exactly when `count` is 0. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Word to write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH | Registered read word |
| thr_load | input | 1 | Load strobe for both thresholds |
| af_level | input | AW+1 | New almost-full margin |
| ae_level | input | AW+1 | New almost-empty level |
| count | output | AW+1 | Number of occupied entries |
| full | output | 1 | Exact full |
| empty | output | 1 | Exact empty |
| full_early | output | 1 | Occupancy at least DEPTH-1 |
| empty_early | output | 1 | Occupancy at most 1 |
| almost_full | output | 1 | Occupancy within the margin of full |
| almost_empty | output | 1 | Occupancy at or below the level |
| overflow | output | 1 | One-cycle pulse for a refused write |
| underflow | output | 1 | One-cycle pulse for a refused read |

## Verification
Every flag and `count` are decoded directly from the two pointers. A corrupted pointer or wrap bit therefore shows at the ports in the very next cycle, as a wrong `count` or as a flag that disagrees with it. A wrong accept decision shows up one cycle later, as a missing or spurious error pulse or a count that fails to step. Damage to the stored words, or to the address used to read them, only appears when the affected entry is read out. For that reason the bench checks every read word against a model queue, including a full drain after overflow has been attempted.

// File: rtl/flagged_fifo.sv
module flagged_fifo #(
  parameter int WIDTH   = 8,
  parameter int DEPTH   = 16,
  parameter int AW      = $clog2(DEPTH),
  parameter int DEF_THR = DEPTH / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic             thr_load,
  input  logic [AW:0]      af_level,
  input  logic [AW:0]      ae_level,
  output logic [AW:0]      count,
  output logic             full,
  output logic             empty,
  output logic             full_early,
  output logic             empty_early,
  output logic             almost_full,
  output logic             almost_empty,
  output logic             overflow,
  output logic             underflow
);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wp, rp;
  logic [AW:0]      af_thr, ae_thr;
  logic             do_wr, do_rd;

  assign empty = (wp == rp);
  assign full  = (wp[AW-1:0] == rp[AW-1:0]) && (wp[AW] != rp[AW]);
  assign count = wp - rp;

  assign do_rd = rd_en && !empty;
  assign do_wr = wr_en && (!full || rd_en);

  assign full_early   = (count >= CW'(DEPTH - 1));
  assign empty_early  = (count <= CW'(1));
  assign almost_full  = ({1'b0, count} + {1'b0, af_thr}) >= (CW+1)'(DEPTH);
  assign almost_empty = (count <= ae_thr);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp        <= '0;
      rp        <= '0;
      rd_data   <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      af_thr    <= CW'(DEF_THR);
      ae_thr    <= CW'(DEF_THR);
    end else begin
      overflow  <= wr_en && full && !rd_en;
      underflow <= rd_en && empty;
      if (do_wr) wp <= wp + CW'(1);
      if (do_rd) begin
        rp      <= rp + CW'(1);
        rd_data <= mem[rp[AW-1:0]];
      end
      if (thr_load) begin
        af_thr <= af_level;
        ae_thr <= ae_level;
      end
    end
  end
endmodule

// File: rtl/flagged_fifo_chk.sv
module flagged_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [CW-1:0] count,
  input logic          full,
  input logic          empty,
  input logic          full_early,
  input logic          empty_early,
  input logic          overflow,
  input logic          underflow
);
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  p_full_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (count == CW'(DEPTH)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (overflow && count == $past(count)));

  p_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en) |=> (underflow && empty));

  p_pass_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && full) |=> (count == CW'(DEPTH) && !overflow));

  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !full) |=> (count == $past(count) + CW'(1)));

  p_early_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> full_early);

  p_early_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> empty_early);
endmodule

bind flagged_fifo flagged_fifo_chk #(.DEPTH(DEPTH), .CW(AW + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .count(count),
  .full(full), .empty(empty), .full_early(full_early),
  .empty_early(empty_early), .overflow(overflow), .underflow(underflow)
);

// File: tb/test_flagged_fifo.sv
module test_flagged_fifo;
  localparam int W  = 8;
  localparam int D  = 16;
  localparam int AW = 4;
  localparam int CW = 5;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, thr_load = 0;
  logic [W-1:0] wr_data = '0, rd_data;
  logic [CW-1:0] af_level = '0, ae_level = '0, count;
  logic full, empty, full_early, empty_early, almost_full, almost_empty;
  logic overflow, underflow;

  flagged_fifo #(.WIDTH(W), .DEPTH(D)) i_flagged_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .thr_load(thr_load),
    .af_level(af_level), .ae_level(ae_level), .count(count),
    .full(full), .empty(empty), .full_early(full_early),
    .empty_early(empty_early), .almost_full(almost_full),
    .almost_empty(almost_empty), .overflow(overflow), .underflow(underflow));

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [W-1:0] q[$];
  logic [W-1:0] last_rd = '0;
  int af_t = D / 8, ae_t = D / 8;

  // {wr, rd, data[7:0], expected count[4:0]}
  localparam logic [14:0] VEC [12] = '{
    {2'b10, 8'h11, 5'd1}, {2'b10, 8'h22, 5'd2}, {2'b11, 8'h33, 5'd2},
    {2'b01, 8'h00, 5'd1}, {2'b01, 8'h00, 5'd0}, {2'b01, 8'h00, 5'd0},
    {2'b11, 8'h44, 5'd1}, {2'b10, 8'h55, 5'd2}, {2'b10, 8'h66, 5'd3},
    {2'b01, 8'h00, 5'd2}, {2'b01, 8'h00, 5'd1}, {2'b01, 8'h00, 5'd0}};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit wr, input bit rd, input logic [W-1:0] d);
    int n = q.size();
    bit isfull = (n == D), isempty = (n == 0);
    bit wacc = wr && (!isfull || rd);
    bit racc = rd && !isempty;
    bit ov = wr && isfull && !rd;
    bit un = rd && isempty;
    wr_en = wr; rd_en = rd; wr_data = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    if (racc) last_rd = q.pop_front();
    if (wacc) q.push_back(d);
    n = q.size();
    check(count == CW'(n), "R4 count", count, n);
    check(full == (n == D), "R11 full", full, n == D);
    check(empty == (n == 0), "R11 empty", empty, n == 0);
    check(full_early == (n >= D - 1), "R8 full_early", full_early, n >= D - 1);
    check(empty_early == (n <= 1), "R8 empty_early", empty_early, n <= 1);
    check(almost_full == (n >= D - af_t), "R9 almost_full", almost_full, n >= D - af_t);
    check(almost_empty == (n <= ae_t), "R9 almost_empty", almost_empty, n <= ae_t);
    check(overflow == ov, "R5 overflow", overflow, ov);
    check(underflow == un, "R6 underflow", underflow, un);
    check(rd_data == last_rd, "R2 rd_data", rd_data, last_rd);
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    check(count == 0 && empty && empty_early && !full, "R1 reset flags", count, 0);
    check(!overflow && !underflow && rd_data == 0, "R1 reset pulses", {overflow, underflow}, 0);
    rst_n = 1;
    q.delete(); last_rd = '0; af_t = D / 8; ae_t = D / 8;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 12; i++) begin
      step(VEC[i][14], VEC[i][13], VEC[i][12:5]);
      check(count == VEC[i][4:0], "R4 table count", count, VEC[i][4:0]);
    end
    for (int i = 0; i < D; i++) step(1, 0, W'(8'h80 + i));
    check(full && count == CW'(D), "R3 all entries usable", count, D);
    step(1, 0, 8'hEE);
    step(0, 0, 8'h00);
    check(!overflow, "R5 pulse one cycle", overflow, 0);
    step(1, 1, 8'hA0);
    check(count == CW'(D) && !overflow, "R7 full pass-through", count, D);
    thr_load = 1; af_level = 5'd5; ae_level = 5'd6;
    @(negedge clk);
    thr_load = 0; af_t = 5; ae_t = 6;
    check(almost_full && !almost_empty, "R10 load thresholds", {almost_full, almost_empty}, 2);
    for (int i = 0; i < D; i++) step(0, 1, 8'h00);
    check(empty && last_rd == 8'hA0, "R2 drain order", last_rd, 8'hA0);
    step(1, 0, 8'h01); step(1, 0, 8'h02); step(1, 0, 8'h03);
    do_reset();
    step(1, 0, 8'h04); step(1, 0, 8'h05); step(1, 0, 8'h06);
    check(!almost_empty, "R10 reset restores threshold", almost_empty, 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule